// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Parking

This block decides which master owns one slave port of a multi-master, multi-slave crossbar. Each cycle it looks at which masters are active, which of them have an address that decodes to this port, and which are still waiting on an access to some other port. From these it drives a one-hot grant, a per-master wait-state line, and a valid strobe toward the slave. A master that already holds the grant is presented in the same cycle, so its access costs no wait state. Any other master waits at least one clock while the arbiter re-assigns the port.

Ownership covers a whole fixed-length burst. A per-beat accept from the slave advances a beat counter. The grant can move only when no burst is under way. Two arbitration policies are available: lowest index first, or rotating. An idle port parks in one of three ways. It can park on a configured master, stay with its most recent owner, or enter a low-power state with no owner.

Top module: `xbar_port_arbiter`

## Requirements
- R1: While reset is held low at a clock edge, the grant is all zero. With no requests, the wait and valid outputs are zero.
- R2: A master that holds the grant, requests this port and is not busy elsewhere drives slave valid high in that same cycle, and its wait bit is low.
- R3: A master whose request hits this port but which does not hold the grant has its wait bit high. It is granted at the next clock edge that falls outside a burst. A request whose target hit is low is ignored: it raises no wait bit and takes no grant.
- R4: A master flagged busy elsewhere is never granted and keeps its wait bit high. A lower-priority requester that is not busy is granted after one arbitration cycle.
- R5: In fixed mode (mode input low), the lowest-indexed eligible requester wins. At the end of a burst, it takes the port from a higher-indexed owner that is still requesting.
- R6: Once a beat is presented, the grant cannot change until BURST_LEN beats have been accepted. A beat with accept low does not count.
- R7: In rotating mode (mode input high), the search for the next owner starts at the index after the current owner (or after the last owner if none) and wraps around. So at the end of a burst the port passes to the next requester in that order.
- R8: With park select 2'b00, an idle port grants the master whose index is on the park-master input.
- R9: With park select 2'b01, an idle port keeps the grant with its current or most recent owner.
- R10: With park select 2'b10 (2'b11 behaves the same), an idle port has no grant, so even the previous owner waits one cycle on its next access.
- R11: The grant is always one-hot or all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_MASTERS | Master is running a non-idle access |
| hit_i | input | N_MASTERS | Master's address decodes to this port |
| busy_i | input | N_MASTERS | Master still has an access outstanding on another port |
| beat_ok_i | input | 1 | Slave accepts the presented beat |
| rr_mode_i | input | 1 | 0 = fixed priority, 1 = rotating |
| park_sel_i | input | 2 | Idle behaviour: 00 park master, 01 last owner, 10/11 no owner |
| park_master_i | input | IW | Index of the configured park master |
| grant_o | output | N_MASTERS | One-hot owner of the port |
| wait_o | output | N_MASTERS | Wait state per master |
| slv_valid_o | output | 1 | Beat presented to the slave |

## Verification
The bench aims at cases where the order of events matters. A higher-priority request arrives in the middle of a burst, so a design that switched owners early would break the burst. The slave stalls on the last beat, so a counter that also counted the stalled cycle would release the port one beat too soon. A busy master is eligible by index but must be passed over, and a design that ignored the busy flag would grant it. In rotating mode the pointer must wrap past index zero, which a design that restarted from zero would get wrong. In the parking cases, a design that mixed up the three modes would either add a cycle of delay for the parked master or remove the cycle that low-power park must add.

// File: rtl/xbar_arb_pkg.sv
// Package: shared types for the crossbar slave-port arbiter.
// Assumes park select is a 2-bit field; the reserved code behaves like no-owner park.
package xbar_arb_pkg;

    typedef enum logic [1:0] {
        PARK_FIXED = 2'b00,
        PARK_LAST  = 2'b01,
        PARK_NONE  = 2'b10,
        PARK_RSVD  = 2'b11
    } park_mode_e;

endpackage

// File: rtl/xarb_burst_track.sv
// Burst tracker: counts accepted beats of the owner's fixed-length burst and
// tells the arbiter when the grant must be held.
// Assumes a beat counts only when it is presented and accepted in the same cycle.
module xarb_burst_track #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present_i,
    input  logic accept_i,
    output logic hold_o
);
    localparam int CW   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int LAST = BURST_LEN - 1;

    logic [CW-1:0] cnt_q;
    logic          fire;
    logic          last_acc;

    // Beat accounting for the current cycle.
    always_comb begin
        fire     = present_i && accept_i;
        last_acc = fire && (cnt_q == CW'(LAST));
        hold_o   = last_acc ? 1'b0 : (present_i || (cnt_q != '0));
    end

    // Beat counter, returns to zero after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= last_acc ? '0 : cnt_q + CW'(1);
        end
    end

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));

    a_r6_cnt_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_acc) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/xarb_pick.sv
// Winner select: fixed lowest-index-first or rotating search after a base index.
// Assumes elig_i already excludes masters busy on another port.
module xarb_pick #(
    parameter int N_MASTERS = 4,
    parameter int IW        = 2
) (
    input  logic [N_MASTERS-1:0] elig_i,
    input  logic                 rr_mode_i,
    input  logic [IW-1:0]        base_i,
    output logic [N_MASTERS-1:0] win_o
);
    logic          found;
    logic [IW-1:0] idx;

    // Choose exactly one eligible master, or none.
    always_comb begin
        win_o = '0;
        found = 1'b0;
        idx   = '0;
        if (!rr_mode_i) begin
            for (int i = 0; i < N_MASTERS; i++) begin
                if (elig_i[i] && !found) begin
                    win_o[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end else begin
            for (int off = 1; off <= N_MASTERS; off++) begin
                idx = IW'((int'(base_i) + off) % N_MASTERS);
                if (elig_i[idx] && !found) begin
                    win_o[idx] = 1'b1;
                    found      = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xbar_port_arbiter.sv
// Slave-port arbiter: owns the grant for one crossbar slave port, presents the
// owner's beats, wait-states everyone else and parks the port when idle.
// Assumes req/hit/busy are stable for the cycle and beats are accepted by beat_ok_i.
module xbar_port_arbiter
    import xbar_arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int BURST_LEN = 4,
    localparam int IW       = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] hit_i,
    input  logic [N_MASTERS-1:0] busy_i,
    input  logic                 beat_ok_i,
    input  logic                 rr_mode_i,
    input  logic [1:0]           park_sel_i,
    input  logic [IW-1:0]        park_master_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic [N_MASTERS-1:0] wait_o,
    output logic                 slv_valid_o
);
    park_mode_e           pmode;
    logic [N_MASTERS-1:0] grant_q, grant_d;
    logic [N_MASTERS-1:0] want, elig, win, park_oh;
    logic [IW-1:0]        last_q, owner_idx, base;
    logic                 present, hold;

    // Request qualification and slave-side presentation.
    always_comb begin
        pmode   = park_mode_e'(park_sel_i);
        want    = req_i & hit_i;
        elig    = want & ~busy_i;
        present = |(grant_q & elig);
    end

    // Index of the current owner and the base for the rotating search.
    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (grant_q[i]) owner_idx = IW'(i);
        end
        base = (|grant_q) ? owner_idx : last_q;
    end

    // Grant vector to use when the port goes idle.
    always_comb begin
        park_oh = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            case (pmode)
                PARK_FIXED: park_oh[i] = (IW'(i) == park_master_i);
                PARK_LAST:  park_oh[i] = (IW'(i) == base);
                default:    park_oh[i] = 1'b0;
            endcase
        end
    end

    xarb_burst_track #(
        .BURST_LEN (BURST_LEN)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .present_i (present),
        .accept_i  (beat_ok_i),
        .hold_o    (hold)
    );

    xarb_pick #(
        .N_MASTERS (N_MASTERS),
        .IW        (IW)
    ) u_pick (
        .elig_i    (elig),
        .rr_mode_i (rr_mode_i),
        .base_i    (base),
        .win_o     (win)
    );

    // Next owner: held during a burst, else winner, else park choice.
    always_comb begin
        if (hold)       grant_d = grant_q;
        else if (|elig) grant_d = win;
        else            grant_d = park_oh;
    end

    // Grant and last-owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            last_q  <= '0;
        end else begin
            grant_q <= grant_d;
            if (|grant_q) last_q <= owner_idx;
        end
    end

    // Output drive.
    always_comb begin
        grant_o     = grant_q;
        wait_o      = want & ~(grant_q & ~busy_i);
        slv_valid_o = present;
    end

    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r6_grant_held_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(grant_o));

    a_r2_valid_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
        slv_valid_o |-> ($countones(grant_o) == 1));

    a_r10_lowpower_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && (elig == '0) && (park_sel_i[1] == 1'b1)) |=> (grant_o == '0));

endmodule

// File: tb/xbar_port_arbiter_tb_top.sv
// Scoreboard bench: the driver task queues the expected outputs of each cycle,
// the monitor pops them at the falling edge and compares.
module xbar_port_arbiter_tb_top;
    localparam int NM = 4;
    localparam int BL = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NM-1:0] req, hit, busy;
    logic          beat_ok, rr_mode;
    logic [1:0]    park_sel;
    logic [1:0]    park_master;
    logic [NM-1:0] grant_o, wait_o;
    logic          slv_valid_o;

    logic          rr_n;
    logic [1:0]    park_n, pm_n;

    int n_checks = 0;
    int n_fail   = 0;

    logic [2*NM:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    xbar_port_arbiter #(.N_MASTERS(NM), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .hit_i(hit), .busy_i(busy),
        .beat_ok_i(beat_ok), .rr_mode_i(rr_mode), .park_sel_i(park_sel),
        .park_master_i(park_master), .grant_o(grant_o), .wait_o(wait_o),
        .slv_valid_o(slv_valid_o)
    );

    task automatic check(input logic [NM-1:0] eg, input logic [NM-1:0] ew,
                         input logic ev, input string tag);
        n_checks++;
        if (grant_o !== eg || wait_o !== ew || slv_valid_o !== ev) begin
            n_fail++;
            $display("FAIL %s: grant=%b wait=%b valid=%b expected grant=%b wait=%b valid=%b",
                     tag, grant_o, wait_o, slv_valid_o, eg, ew, ev);
        end
    endtask

    // Driver: one cycle of stimulus plus the outputs expected in that cycle.
    task automatic step(input logic [NM-1:0] rq, input logic [NM-1:0] hi,
                        input logic [NM-1:0] bz, input logic bt,
                        input logic [NM-1:0] eg, input logic [NM-1:0] ew,
                        input logic ev, input string tag);
        @(posedge clk);
        #1;
        req = rq; hit = hi; busy = bz; beat_ok = bt;
        rr_mode = rr_n; park_sel = park_n; park_master = pm_n;
        exp_q.push_back({eg, ew, ev});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [2*NM:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(e[2*NM:NM+1], e[NM:1], e[0], t);
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req = '0; hit = '0; busy = '0; beat_ok = 1'b0;
        rr_n = 1'b0; park_n = 2'b10; pm_n = 2'd0;
        rr_mode = 1'b0; park_sel = 2'b10; park_master = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(4'b0000, 4'b0000, 1'b0, "R1 reset state");
        @(posedge clk);
        #1 rst_n = 1'b1;

        // Low-power park, fixed priority.
        step(4'b0001, 4'b0000, 4'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, "R3 miss ignored");
        step(4'b0010, 4'b0010, 4'b0, 1'b0, 4'b0000, 4'b0010, 1'b0, "R3 arbitration wait");
        step(4'b0010, 4'b0010, 4'b0, 1'b1, 4'b0010, 4'b0000, 1'b1, "R3 granted next cycle");
        step(4'b0011, 4'b0011, 4'b0, 1'b1, 4'b0010, 4'b0001, 1'b1, "R6 no preempt beat2");
        step(4'b0011, 4'b0011, 4'b0, 1'b1, 4'b0010, 4'b0001, 1'b1, "R6 no preempt beat3");
        step(4'b0011, 4'b0011, 4'b0, 1'b0, 4'b0010, 4'b0001, 1'b1, "R6 stall not counted");
        step(4'b0011, 4'b0011, 4'b0, 1'b1, 4'b0010, 4'b0001, 1'b1, "R6 final beat");
        for (int k = 0; k < 3; k++)
            step(4'b0011, 4'b0011, 4'b0, 1'b1, 4'b0001, 4'b0010, 1'b1, "R5 lowest index wins");
        step(4'b0001, 4'b0001, 4'b0, 1'b1, 4'b0001, 4'b0000, 1'b1, "R2 owner zero wait");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0001, 4'b0000, 1'b0, "R10 owner idle");
        step(4'b0001, 4'b0001, 4'b0, 1'b0, 4'b0000, 4'b0001, 1'b0, "R10 last owner waits");
        step(4'b0001, 4'b0001, 4'b0, 1'b0, 4'b0001, 4'b0000, 1'b1, "R10 granted after wait");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0001, 4'b0000, 1'b0, "R11 single owner");

        // Park on configured master 2.
        park_n = 2'b00; pm_n = 2'd2;
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, "R10 unowned before park");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0100, 4'b0000, 1'b0, "R8 parked on master 2");
        for (int k = 0; k < 4; k++)
            step(4'b0100, 4'b0100, 4'b0, 1'b1, 4'b0100, 4'b0000, 1'b1, "R2 parked zero wait");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0100, 4'b0000, 1'b0, "R8 stays parked");

        // Busy-elsewhere master skipped.
        step(4'b0011, 4'b0011, 4'b0001, 1'b0, 4'b0100, 4'b0011, 1'b0, "R4 both wait");
        for (int k = 0; k < 4; k++)
            step(4'b0011, 4'b0011, 4'b0001, 1'b1, 4'b0010, 4'b0001, 1'b1, "R4 busy master held off");
        step(4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0010, 4'b0001, 1'b0, "R4 busy cleared waits");
        step(4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b1, "R4 granted after clear");
        step(4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b0, "R8 idle again");
        step(4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0100, 4'b0000, 1'b0, "R8 returns to park");

        // Rotating mode, park on last owner.
        rr_n = 1'b1; park_n = 2'b01;
        for (int k = 0; k < 4; k++)
            step(4'b1110, 4'b1110, 4'b0, 1'b1, 4'b0100, 4'b1010, 1'b1, "R7 owner 2 burst");
        for (int k = 0; k < 4; k++)
            step(4'b1110, 4'b1110, 4'b0, 1'b1, 4'b1000, 4'b0110, 1'b1, "R7 handoff to 3");
        for (int k = 0; k < 4; k++)
            step(4'b1110, 4'b1110, 4'b0, 1'b1, 4'b0010, 4'b1100, 1'b1, "R7 wrap to 1");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0100, 4'b0000, 1'b0, "R7 handoff to 2");
        step(4'b0000, 4'b0000, 4'b0, 1'b0, 4'b0100, 4'b0000, 1'b0, "R9 park on last owner");
        step(4'b0100, 4'b0100, 4'b0, 1'b0, 4'b0100, 4'b0000, 1'b1, "R9 last owner zero wait");

        @(posedge clk);
        @(negedge clk);
        #1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule